// File: doc/BRIEF.md
# Clock Domain Sleep Manager

This block controls the clocks of one clock domain. It holds the domain in one of three states: active, idle-transition or inactive. It produces an enable for each module's interface clock and for each functional clock. The enables are registered, so they can drive integrated clock-gating cells directly.

Hardware conditions gate the interface clocks of all modules together. Software may allow the domain to sleep. When it does and no wake-up request is pending, the block leaves the active state for the idle-transition state. Once every module reports idle or standby, the block switches off all interface clocks. The domain is declared inactive only after every domain clock is gated. A wake-up request, or software withdrawing the sleep permission, aborts the attempt. A wake-up request also ends the inactive state.

Functional clocks are never switched by the state machine. Each one follows its own software enable, so the clocks of one module can run while another module's clocks are stopped. An activity status bit per functional clock reports whether that clock is running.

Top module: `clk_domain_sleep_mgr`

## Requirements
- R1: Synchronous active-high `rst` places the block in the active state (`dom_state_o` = 0) with every `iclk_en_o` bit, every `fclk_en_o` bit and every `fclk_active_o` bit at 1. State encoding: 0 active, 1 idle-transition, 2 inactive.
- R2: In the active state, if `sleep_allow_i`=1 and `wake_req_i`=0 at a clock edge, the state becomes idle-transition at that edge. Otherwise the state stays active and `iclk_en_o` stays all ones.
- R3: In idle-transition, if every module has `mod_idle_i` or `mod_stby_i` set and the block stays in idle-transition, all `iclk_en_o` bits go to 0 together at that edge. If any module is neither idle nor in standby, all `iclk_en_o` bits are 1 after the edge.
- R4: Idle-transition becomes inactive at an edge only if all of the following hold: `iclk_en_o` is already all zeros, every module is idle or in standby, every `fclk_en_o` bit is 0, and the sleep condition holds. Otherwise the block stays in idle-transition, for example while a functional clock is still running.
- R5: In idle-transition, `sleep_allow_i`=0 returns the block to active at the next edge, with all `iclk_en_o` bits at 1 from that same edge.
- R6: In idle-transition, `wake_req_i`=1 forces a return to active at the next edge, with `iclk_en_o` all ones. This holds even when every condition for entering inactive is met.
- R7: In inactive, `wake_req_i`=1 returns the block to active at the next edge, with `iclk_en_o` all ones. Without a wake-up request the block stays inactive, even if `sleep_allow_i` drops or a module becomes busy.
- R8: Each `fclk_en_o[k]` equals `fclk_sw_en_i[k]` one edge later, in every state and independently of the other functional clocks.
- R9: `fclk_active_o[k]` reads 1 when functional clock k is enabled and 0 when it is gated.
- R10: While the block is inactive, every `iclk_en_o` bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain control clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_idle_i | input | N_MOD | Per-module idle indication |
| mod_stby_i | input | N_MOD | Per-module standby indication |
| fclk_sw_en_i | input | N_FCLK | Software enable per functional clock |
| sleep_allow_i | input | 1 | Software permission for the domain to sleep |
| wake_req_i | input | 1 | Wake-up request |
| iclk_en_o | output | N_MOD | Interface clock enable per module |
| fclk_en_o | output | N_FCLK | Functional clock enable |
| fclk_active_o | output | N_FCLK | Activity status per functional clock |
| dom_state_o | output | 2 | Domain state (0 active, 1 idle-transition, 2 inactive) |

## Verification
Every result of this block is due at the first rising edge after its cause. State changes, interface clock enables, functional clock enables and activity status all come from registers loaded at one edge, with no further pipeline stage. The bench applies each vector's inputs on a falling edge and lets one rising edge pass. It compares all outputs on the following falling edge, before the next vector is driven. Two-step effects are covered by consecutive vectors that each check one edge. One such effect is interface clocks switching off in one cycle and the inactive state being entered in the next.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

    typedef enum logic [1:0] {
        DOM_ACTIVE     = 2'd0,
        DOM_IDLE_TRANS = 2'd1,
        DOM_INACTIVE   = 2'd2
    } dom_state_e;

    typedef struct packed {
        logic sleep_cond;
        logic wake;
        logic all_quiet;
        logic iclk_off;
        logic fclk_off;
    } dom_cond_t;

    function automatic dom_state_e dom_next(input dom_state_e cur, input dom_cond_t c);
        dom_state_e nxt;
        nxt = cur;
        case (cur)
            DOM_ACTIVE: begin
                if (c.sleep_cond) nxt = DOM_IDLE_TRANS;
            end
            DOM_IDLE_TRANS: begin
                if (!c.sleep_cond)
                    nxt = DOM_ACTIVE;
                else if (c.all_quiet && c.iclk_off && c.fclk_off)
                    nxt = DOM_INACTIVE;
            end
            DOM_INACTIVE: begin
                if (c.wake) nxt = DOM_ACTIVE;
            end
            default: nxt = DOM_ACTIVE;
        endcase
        return nxt;
    endfunction

    function automatic logic iclk_gate_next(input dom_state_e cur,
                                            input dom_state_e nxt,
                                            input logic all_quiet);
        return (nxt == DOM_INACTIVE) ||
               ((cur == DOM_IDLE_TRANS) && (nxt == DOM_IDLE_TRANS) && all_quiet);
    endfunction

endpackage

// File: rtl/cdsm_cond.sv
module cdsm_cond
    import clkdom_pkg::*;
#(
    parameter int N_MOD  = 3,
    parameter int N_FCLK = 2
) (
    input  logic [N_MOD-1:0]  mod_idle,
    input  logic [N_MOD-1:0]  mod_stby,
    input  logic [N_MOD-1:0]  iclk_en,
    input  logic [N_FCLK-1:0] fclk_en,
    input  logic              sleep_allow,
    input  logic              wake_req,
    output dom_cond_t         cond
);
    logic [N_MOD-1:0] quiet;

    for (genvar m = 0; m < N_MOD; m++) begin : g_quiet
        assign quiet[m] = mod_idle[m] | mod_stby[m];
    end

    always_comb begin
        cond.sleep_cond = sleep_allow & ~wake_req;
        cond.wake       = wake_req;
        cond.all_quiet  = &quiet;
        cond.iclk_off   = ~|iclk_en;
        cond.fclk_off   = ~|fclk_en;
    end
endmodule

// File: rtl/cdsm_seq.sv
module cdsm_seq
    import clkdom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dom_cond_t  cond,
    output dom_state_e state,
    output dom_state_e state_nxt
);
    assign state_nxt = dom_next(state, cond);

    always_ff @(posedge clk) begin
        if (rst) state <= DOM_ACTIVE;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/cdsm_iclk_bank.sv
module cdsm_iclk_bank
    import clkdom_pkg::*;
#(
    parameter int N_MOD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  dom_state_e       state,
    input  dom_state_e       state_nxt,
    input  logic             all_quiet,
    output logic [N_MOD-1:0] iclk_en
);
    logic gate_off;

    assign gate_off = iclk_gate_next(state, state_nxt, all_quiet);

    for (genvar m = 0; m < N_MOD; m++) begin : g_iclk
        always_ff @(posedge clk) begin
            if (rst) iclk_en[m] <= 1'b1;
            else     iclk_en[m] <= ~gate_off;
        end
    end
endmodule

// File: rtl/cdsm_fclk_bank.sv
module cdsm_fclk_bank #(
    parameter int N_FCLK = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FCLK-1:0] sw_en,
    output logic [N_FCLK-1:0] fclk_en,
    output logic [N_FCLK-1:0] fclk_active
);
    for (genvar k = 0; k < N_FCLK; k++) begin : g_fclk
        always_ff @(posedge clk) begin
            if (rst) fclk_en[k] <= 1'b1;
            else     fclk_en[k] <= sw_en[k];
        end
        assign fclk_active[k] = fclk_en[k];
    end
endmodule

// File: rtl/clk_domain_sleep_mgr.sv
module clk_domain_sleep_mgr
    import clkdom_pkg::*;
#(
    parameter int N_MOD  = 3,
    parameter int N_FCLK = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_MOD-1:0]  mod_idle_i,
    input  logic [N_MOD-1:0]  mod_stby_i,
    input  logic [N_FCLK-1:0] fclk_sw_en_i,
    input  logic              sleep_allow_i,
    input  logic              wake_req_i,
    output logic [N_MOD-1:0]  iclk_en_o,
    output logic [N_FCLK-1:0] fclk_en_o,
    output logic [N_FCLK-1:0] fclk_active_o,
    output logic [1:0]        dom_state_o
);
    dom_cond_t  cond;
    dom_state_e state;
    dom_state_e state_nxt;

    cdsm_cond #(.N_MOD(N_MOD), .N_FCLK(N_FCLK)) u_cond (
        .mod_idle    (mod_idle_i),
        .mod_stby    (mod_stby_i),
        .iclk_en     (iclk_en_o),
        .fclk_en     (fclk_en_o),
        .sleep_allow (sleep_allow_i),
        .wake_req    (wake_req_i),
        .cond        (cond)
    );

    cdsm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cond      (cond),
        .state     (state),
        .state_nxt (state_nxt)
    );

    cdsm_iclk_bank #(.N_MOD(N_MOD)) u_iclk (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .state_nxt (state_nxt),
        .all_quiet (cond.all_quiet),
        .iclk_en   (iclk_en_o)
    );

    cdsm_fclk_bank #(.N_FCLK(N_FCLK)) u_fclk (
        .clk         (clk),
        .rst         (rst),
        .sw_en       (fclk_sw_en_i),
        .fclk_en     (fclk_en_o),
        .fclk_active (fclk_active_o)
    );

    assign dom_state_o = state;
endmodule

// File: rtl/cdsm_checker.sv
module cdsm_checker #(
    parameter int N_MOD  = 3,
    parameter int N_FCLK = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [N_MOD-1:0]  idle,
    input logic [N_MOD-1:0]  stby,
    input logic [N_FCLK-1:0] fsw,
    input logic              sa,
    input logic              wk,
    input logic [N_MOD-1:0]  iclk,
    input logic [N_FCLK-1:0] fclk,
    input logic [1:0]        st
);
    logic quiet;
    assign quiet = &(idle | stby);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (st == 2'd0) && (&iclk) && (&fclk));

    p_enter_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd0 && sa && !wk) |=> (st == 2'd1));

    p_gate_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && sa && !wk && quiet && (iclk != '0 || fclk != '0)) |=> (iclk == '0));

    p_no_early_sleep_r4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && sa && !wk && (!quiet || iclk != '0 || fclk != '0)) |=> (st == 2'd1));

    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && !sa) |=> (st == 2'd0) && (&iclk));

    p_wake_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd1 && wk) |=> (st == 2'd0) && (&iclk));

    p_wake_inact_r7: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd2 && wk) |=> (st == 2'd0) && (&iclk));

    p_fclk_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fclk == $past(fsw)));

    p_inact_gated_r10: assert property (@(posedge clk) disable iff (rst)
        (st == 2'd2) |-> (iclk == '0));

    p_legal_state_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st != 2'd3));
endmodule

bind clk_domain_sleep_mgr cdsm_checker #(.N_MOD(N_MOD), .N_FCLK(N_FCLK)) u_cdsm_chk (
    .clk  (clk),
    .rst  (rst),
    .idle (mod_idle_i),
    .stby (mod_stby_i),
    .fsw  (fclk_sw_en_i),
    .sa   (sleep_allow_i),
    .wk   (wake_req_i),
    .iclk (iclk_en_o),
    .fclk (fclk_en_o),
    .st   (dom_state_o)
);

// File: tb/test_clk_domain_sleep_mgr.sv
`timescale 1ns/1ps
module test_clk_domain_sleep_mgr;
    localparam int NM = 3;
    localparam int NF = 2;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [NM-1:0] idle, stby, iclk;
    logic [NF-1:0] fsw, fclk, fact;
    logic          sa, wk;
    logic [1:0]    st;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    clk_domain_sleep_mgr #(.N_MOD(NM), .N_FCLK(NF)) i_clk_domain_sleep_mgr (
        .clk(clk), .rst(rst), .mod_idle_i(idle), .mod_stby_i(stby),
        .fclk_sw_en_i(fsw), .sleep_allow_i(sa), .wake_req_i(wk),
        .iclk_en_o(iclk), .fclk_en_o(fclk), .fclk_active_o(fact),
        .dom_state_o(st)
    );

    // {sa, wk, idle[2:0], stby[2:0], fsw[1:0], exp_state[1:0], exp_iclk[2:0], exp_fclk[1:0]}
    localparam logic [16:0] VEC [NV] = '{
        17'b0_0_000_000_11_00_111_11, // R2 stay active
        17'b1_0_000_000_11_01_111_11, // R2 enter idle-transition
        17'b1_0_011_100_00_01_000_00, // R3 gate interface clocks
        17'b1_0_011_100_00_10_000_00, // R4 enter inactive
        17'b0_0_000_000_00_10_000_00, // R7 R10 stay inactive
        17'b1_1_000_000_00_00_111_00, // R7 wake
        17'b1_0_111_000_01_01_111_01, // R2
        17'b1_0_111_000_01_01_000_01, // R3
        17'b1_0_111_000_01_01_000_01, // R4 functional clock still on
        17'b1_0_110_000_01_01_111_01, // R3 module busy again
        17'b1_0_111_000_00_01_000_00, // R3
        17'b1_1_111_000_00_00_111_00, // R6 wake priority
        17'b1_0_111_000_00_01_111_00, // R2
        17'b1_0_111_000_00_01_000_00, // R3
        17'b0_0_111_000_00_00_111_00, // R5 abort
        17'b0_0_000_000_10_00_111_10  // R8 independent clocks
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; sa = 0; wk = 0; idle = '0; stby = '0; fsw = '1;
        step(); step();
        chk("R1 state", st, 0);
        chk("R1 iclk", iclk, 3'b111);
        chk("R1 fclk", fclk, 2'b11);
        chk("R1 status", fact, 2'b11);
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            {sa, wk, idle, stby, fsw} = VEC[v][16:7];
            step();
            chk($sformatf("vec%0d state R2-path", v), st, VEC[v][6:5]);
            chk($sformatf("vec%0d iclk R3", v), iclk, VEC[v][4:2]);
            chk($sformatf("vec%0d fclk R8", v), fclk, VEC[v][1:0]);
            chk($sformatf("vec%0d status R9", v), fact, VEC[v][1:0]);
        end
        // Directed: reach inactive, then reset mid-operation
        sa = 1; wk = 0; idle = '1; stby = '0; fsw = '0;
        step(); step(); step();
        chk("R10 inactive reached", st, 2);
        chk("R10 iclk gated", iclk, 0);
        chk("R9 status gated", fact, 0);
        rst = 1'b1;
        step();
        chk("R1 reset from inactive state", st, 0);
        chk("R1 reset iclk", iclk, 3'b111);
        chk("R1 reset status", fact, 2'b11);
        rst = 1'b0;
        // R6: wake on the very cycle inactive entry would otherwise happen
        step(); step();
        chk("R3 gated before wake", iclk, 0);
        wk = 1;
        step();
        chk("R6 wake priority state", st, 0);
        chk("R6 wake iclk", iclk, 3'b111);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule